// File: doc/BRIEF.md
# Reservation-Queue Circuit Switch Allocator

This block controls the data-plane crossbar of one five-port mesh router. The ports are North, South, East, West and Local. A control-plane side interface hands in reservations, one per cycle. Each reservation names an input port and an output port. The block appends the output to the queue of that input, and appends the input to the queue of that output. Every port keeps its own strictly ordered queue.

A crossbar path from input i to output o is closed only when two conditions hold together: the head of i's queue names o, and the head of o's queue names i. The data flits of that circuit then flow straight through in the same cycle they are presented. When the last flit of the fixed-length packet leaves, both queue heads are retired and the path is released.

Reservations are taken in advance, even while the ports they name are carrying another circuit. The control plane is held off only when a queue is full.

Port encoding used throughout: North = 0, South = 1, East = 2, West = 3, Local = 4.

Top module: `circuit_switch_alloc`

## Requirements
- R1: With the port encoding North=0, South=1, East=2, West=3, Local=4, a reservation is taken on a cycle where `rsv_valid` and `rsv_ready` are both high and the pair is legal. A taken reservation is appended to the tail of the input's queue and to the tail of the output's queue.
- R2: Input i is connected to output o only when the head of i's queue is o and the head of o's queue is i. Flits are accepted from the second clock edge after the reservation edge onward.
- R3: Each queue holds QDEPTH entries, 8 by default. `rsv_ready` is low while the input queue or the output queue named by the reservation is full.
- R4: A reservation for ports that are currently carrying a circuit is still accepted, with `rsv_ready` high and `rsv_err` low.
- R5: Circuits cross each port in the order of their reservations. An input whose queue head is not yet at the head of its output's queue is held with `in_ready` low.
- R6: Up to five circuits may be active at once, one per output. An input drives at most one output.
- R7: A packet is PKT_FLITS flits long, 7 by default. The edge that takes the last flit releases the path and retires both queue heads, so that input is not ready on the next cycle unless a new circuit forms.
- R8: `rsv_err` is high in the same cycle as an offered reservation that is not ready, that names the same port for input and output (except Local to Local), or that names a port index above 4. Such a reservation is not queued.
- R9: A flit at an input without an active circuit sees `in_ready` low and produces no `out_valid`.
- R10: On an active circuit, `out_valid` and `out_data` of the output follow the input's valid and data in the same cycle. An output with no active circuit shows `out_valid` low and all-zero data.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Data-plane clock |
| rst_n | input | 1 | Active-low synchronous reset |
| rsv_valid | input | 1 | A reservation is offered |
| rsv_in | input | 3 | Input port of the reservation |
| rsv_out | input | 3 | Output port of the reservation |
| rsv_ready | output | 1 | Both target queues have room |
| rsv_err | output | 1 | Offered reservation refused (not ready or illegal) |
| in_valid | input | 5 | Flit present, one bit per input port |
| in_data | input | 5*FLIT_W | Flit payloads, port p at bits [p*FLIT_W +: FLIT_W] |
| in_ready | output | 5 | Flit taken this cycle, one bit per input port |
| out_valid | output | 5 | Flit leaving, one bit per output port |
| out_data | output | 5*FLIT_W | Outgoing payloads, port p at bits [p*FLIT_W +: FLIT_W] |

## Verification
The hardest situation to reach from the ports is disagreement between queue heads. An input's head names an output whose own head still belongs to another input, so a flit must wait while its reservation is already queued. The stimulus creates this by queueing two circuits into East from Local and then West. It then presents West's flits first and shows them held until Local's whole packet has drained. A second hard case is a queue at capacity: eight reservations are stacked on one pair with no data moving. Refused offers into the full input side and the full output side are then checked, and the drain afterwards proves that nothing refused was queued.

// File: rtl/csa_pkg.sv
package csa_pkg;
  localparam int NPORT = 5;
  localparam int PW    = 3;
  localparam int LOCAL = 4;

  // A reservation is legal when both ports exist and it is not a U-turn,
  // except Local to Local, which is allowed.
  function automatic logic rsv_legal(logic [PW-1:0] pin, logic [PW-1:0] pout);
    return (int'(pin) < NPORT) && (int'(pout) < NPORT) &&
           ((pin != pout) || (int'(pin) == LOCAL));
  endfunction

  function automatic logic flit_is_tail(int unsigned idx, int unsigned len);
    return idx == len - 1;
  endfunction
endpackage

// File: rtl/csa_fifo.sv
module csa_fifo #(
  parameter int W     = 3,
  parameter int DEPTH = 8,
  localparam int AW   = (DEPTH > 1) ? $clog2(DEPTH) : 1,
  localparam int CNTW = $clog2(DEPTH + 1)
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            push,
  input  logic [W-1:0]    din,
  input  logic            pop,
  output logic [W-1:0]    dout,
  output logic            empty,
  output logic            full,
  output logic [CNTW-1:0] count
);
  logic [W-1:0]  mem [DEPTH];
  logic [AW-1:0] wptr, rptr;

  function automatic logic [AW-1:0] bump(logic [AW-1:0] p);
    return (int'(p) == DEPTH - 1) ? '0 : p + 1'b1;
  endfunction

  assign empty = (count == '0);
  assign full  = (int'(count) == DEPTH);
  assign dout  = mem[rptr];

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      wptr  <= '0;
      rptr  <= '0;
      count <= '0;
    end else begin
      if (push) begin
        mem[wptr] <= din;
        wptr      <= bump(wptr);
      end
      if (pop) rptr <= bump(rptr);
      case ({push, pop})
        2'b10:   count <= count + 1'b1;
        2'b01:   count <= count - 1'b1;
        default: count <= count;
      endcase
    end
  end
endmodule

// File: rtl/csa_conn.sv
module csa_conn
  import csa_pkg::*;
#(
  parameter int PKT_FLITS = 7,
  localparam int CW       = $clog2(PKT_FLITS + 1)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          agree,
  input  logic [PW-1:0] head_src,
  input  logic          src_valid,
  output logic          active,
  output logic [PW-1:0] src,
  output logic [CW-1:0] cnt,
  output logic          fire,
  output logic          tail
);
  assign fire = active && src_valid;
  assign tail = fire && flit_is_tail(int'(cnt), PKT_FLITS);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      active <= 1'b0;
      src    <= '0;
      cnt    <= '0;
    end else if (!active) begin
      if (agree) begin
        active <= 1'b1;
        src    <= head_src;
        cnt    <= '0;
      end
    end else if (fire) begin
      if (tail) begin
        active <= 1'b0;
        cnt    <= '0;
      end else begin
        cnt <= cnt + 1'b1;
      end
    end
  end
endmodule

// File: rtl/circuit_switch_alloc.sv
module circuit_switch_alloc
  import csa_pkg::*;
#(
  parameter int FLIT_W    = 80,
  parameter int QDEPTH    = 8,
  parameter int PKT_FLITS = 7,
  localparam int CNTW     = $clog2(QDEPTH + 1),
  localparam int CW       = $clog2(PKT_FLITS + 1)
) (
  input  logic                    clk,
  input  logic                    rst_n,
  input  logic                    rsv_valid,
  input  logic [PW-1:0]           rsv_in,
  input  logic [PW-1:0]           rsv_out,
  output logic                    rsv_ready,
  output logic                    rsv_err,
  input  logic [NPORT-1:0]        in_valid,
  input  logic [NPORT*FLIT_W-1:0] in_data,
  output logic [NPORT-1:0]        in_ready,
  output logic [NPORT-1:0]        out_valid,
  output logic [NPORT*FLIT_W-1:0] out_data
);
  logic [NPORT-1:0][PW-1:0]   iq_head, oq_head;
  logic [NPORT-1:0]           iq_empty, iq_full, iq_push, iq_pop;
  logic [NPORT-1:0]           oq_empty, oq_full, oq_push, oq_pop;
  logic [NPORT-1:0][CNTW-1:0] iq_count, oq_count;

  logic [NPORT-1:0]           conn_active, conn_fire, conn_tail, conn_agree, conn_srcv;
  logic [NPORT-1:0][PW-1:0]   conn_src;
  logic [NPORT-1:0][CW-1:0]   conn_cnt;

  logic rsv_blocked, rsv_accept;

  // Reservation side: a queue that is full blocks only the ports it serves.
  always_comb begin
    rsv_blocked = 1'b0;
    for (int p = 0; p < NPORT; p++) begin
      if (rsv_in  == PW'(p) && iq_full[p]) rsv_blocked = 1'b1;
      if (rsv_out == PW'(p) && oq_full[p]) rsv_blocked = 1'b1;
    end
  end

  assign rsv_ready  = !rsv_blocked;
  assign rsv_accept = rsv_valid && rsv_ready && rsv_legal(rsv_in, rsv_out);
  assign rsv_err    = rsv_valid && (!rsv_ready || !rsv_legal(rsv_in, rsv_out));

  // Per-port queues, one instance for each side of every port.
  for (genvar p = 0; p < NPORT; p++) begin : g_port
    assign iq_push[p] = rsv_accept && (rsv_in  == PW'(p));
    assign oq_push[p] = rsv_accept && (rsv_out == PW'(p));
    assign oq_pop[p]  = conn_tail[p];

    csa_fifo #(.W(PW), .DEPTH(QDEPTH)) u_iq (
      .clk(clk), .rst_n(rst_n), .push(iq_push[p]), .din(rsv_out),
      .pop(iq_pop[p]), .dout(iq_head[p]), .empty(iq_empty[p]),
      .full(iq_full[p]), .count(iq_count[p]));

    csa_fifo #(.W(PW), .DEPTH(QDEPTH)) u_oq (
      .clk(clk), .rst_n(rst_n), .push(oq_push[p]), .din(rsv_in),
      .pop(oq_pop[p]), .dout(oq_head[p]), .empty(oq_empty[p]),
      .full(oq_full[p]), .count(oq_count[p]));

    csa_conn #(.PKT_FLITS(PKT_FLITS)) u_conn (
      .clk(clk), .rst_n(rst_n), .agree(conn_agree[p]), .head_src(oq_head[p]),
      .src_valid(conn_srcv[p]), .active(conn_active[p]), .src(conn_src[p]),
      .cnt(conn_cnt[p]), .fire(conn_fire[p]), .tail(conn_tail[p]));
  end

  // Head matching: output o forms a path when its head input names it back.
  always_comb begin
    conn_agree = '0;
    for (int o = 0; o < NPORT; o++)
      for (int i = 0; i < NPORT; i++)
        if (!oq_empty[o] && oq_head[o] == PW'(i) &&
            !iq_empty[i] && iq_head[i] == PW'(o))
          conn_agree[o] = 1'b1;
  end

  // Crossbar: steer data, valid and ready along the active paths.
  always_comb begin
    conn_srcv = '0;
    in_ready  = '0;
    iq_pop    = '0;
    out_data  = '0;
    for (int o = 0; o < NPORT; o++)
      for (int i = 0; i < NPORT; i++)
        if (conn_active[o] && conn_src[o] == PW'(i)) begin
          conn_srcv[o]                 = in_valid[i];
          in_ready[i]                  = 1'b1;
          iq_pop[i]                    = conn_tail[o];
          out_data[o*FLIT_W +: FLIT_W] = in_data[i*FLIT_W +: FLIT_W];
        end
  end

  assign out_valid = conn_fire;
endmodule

// File: rtl/csa_checks.sv
module csa_checks
  import csa_pkg::*;
#(
  parameter int QDEPTH    = 8,
  parameter int PKT_FLITS = 7,
  localparam int CNTW     = $clog2(QDEPTH + 1),
  localparam int CW       = $clog2(PKT_FLITS + 1)
) (
  input logic                       clk,
  input logic                       rst_n,
  input logic [NPORT-1:0]           conn_active,
  input logic [NPORT-1:0]           conn_tail,
  input logic [NPORT-1:0][PW-1:0]   conn_src,
  input logic [NPORT-1:0][CW-1:0]   conn_cnt,
  input logic [NPORT-1:0][CNTW-1:0] iq_count,
  input logic [NPORT-1:0][CNTW-1:0] oq_count
);
  for (genvar p = 0; p < NPORT; p++) begin : g_chk
    logic [NPORT-1:0] drives;
    always_comb
      for (int o = 0; o < NPORT; o++)
        drives[o] = conn_active[o] && (conn_src[o] == PW'(p));

    a_r6_input_single: assert property (@(posedge clk) disable iff (!rst_n)
      $onehot0(drives));

    a_r3_queue_bounded: assert property (@(posedge clk) disable iff (!rst_n)
      (int'(iq_count[p]) <= QDEPTH) && (int'(oq_count[p]) <= QDEPTH));

    a_r7_tail_release: assert property (@(posedge clk) disable iff (!rst_n)
      conn_tail[p] |=> !conn_active[p]);

    a_r2_circuit_stable: assert property (@(posedge clk) disable iff (!rst_n)
      (conn_active[p] && !conn_tail[p]) |=> (conn_active[p] && $stable(conn_src[p])));

    a_r7_count_range: assert property (@(posedge clk) disable iff (!rst_n)
      int'(conn_cnt[p]) < PKT_FLITS);
  end
endmodule

bind circuit_switch_alloc csa_checks #(.QDEPTH(QDEPTH), .PKT_FLITS(PKT_FLITS)) u_csa_checks (
  .clk(clk), .rst_n(rst_n), .conn_active(conn_active), .conn_tail(conn_tail),
  .conn_src(conn_src), .conn_cnt(conn_cnt), .iq_count(iq_count), .oq_count(oq_count));

// File: tb/test_circuit_switch_alloc.sv
module test_circuit_switch_alloc;
  localparam int CLK_PERIOD = 10;
  localparam int FW   = 80;
  localparam int QD   = 8;
  localparam int PKT  = 7;
  localparam int NP   = 5;
  localparam int N = 0, S = 1, E = 2, W = 3, L = 4;

  logic clk = 1'b0, rst_n = 1'b0;
  logic rsv_valid = 1'b0;
  logic [2:0] rsv_in = '0, rsv_out = '0;
  logic rsv_ready, rsv_err;
  logic [NP-1:0] in_valid = '0, in_ready, out_valid;
  logic [NP*FW-1:0] in_data = '0, out_data;

  int n_chk = 0, n_bad = 0;
  bit finished = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  circuit_switch_alloc #(.FLIT_W(FW), .QDEPTH(QD), .PKT_FLITS(PKT)) i_circuit_switch_alloc (
    .clk(clk), .rst_n(rst_n), .rsv_valid(rsv_valid), .rsv_in(rsv_in), .rsv_out(rsv_out),
    .rsv_ready(rsv_ready), .rsv_err(rsv_err), .in_valid(in_valid), .in_data(in_data),
    .in_ready(in_ready), .out_valid(out_valid), .out_data(out_data));

  task automatic chk(bit ok, string req, logic [127:0] act, logic [127:0] exp);
    n_chk++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  function automatic logic [FW-1:0] flit(int base, int port, int k);
    return FW'(base * 4096 + port * 256 + k + 1);
  endfunction

  task automatic do_rsv(int pin, int pout, bit exp_rdy, bit exp_err, string req);
    @(negedge clk);
    rsv_valid = 1'b1; rsv_in = 3'(pin); rsv_out = 3'(pout);
    #1;
    chk(rsv_ready == exp_rdy, {req, " rsv_ready"}, 128'(rsv_ready), 128'(exp_rdy));
    chk(rsv_err == exp_err, {req, " rsv_err"}, 128'(rsv_err), 128'(exp_err));
    @(negedge clk);
    rsv_valid = 1'b0;
  endtask

  // Drives one packet on each selected input; every taken flit must appear on dst.
  task automatic run_flits(logic [NP-1:0] act, int dst [NP], int base, string req);
    int k [NP];
    int guard = 0;
    bit done;
    k = '{default: 0};
    forever begin
      done = 1;
      for (int i = 0; i < NP; i++) if (act[i] && k[i] < PKT) done = 0;
      if (done) break;
      @(negedge clk);
      for (int i = 0; i < NP; i++) begin
        in_valid[i] = act[i] && (k[i] < PKT);
        in_data[i*FW +: FW] = flit(base, i, k[i]);
      end
      #1;
      for (int i = 0; i < NP; i++)
        if (in_valid[i] && in_ready[i]) begin
          chk(out_valid[dst[i]] == 1'b1, {req, " out_valid"}, 128'(out_valid[dst[i]]), 128'(1));
          chk(out_data[dst[i]*FW +: FW] == flit(base, i, k[i]), {req, " out_data"},
              128'(out_data[dst[i]*FW +: FW]), 128'(flit(base, i, k[i])));
          k[i]++;
        end
      guard++;
      if (guard > 300) begin
        chk(1'b0, {req, " packet stalled"}, 128'(guard), 128'(PKT));
        break;
      end
    end
    @(negedge clk);
    in_valid = '0;
  endtask

  task automatic t_reset;
    @(negedge clk); #1;
    chk(rsv_ready == 1'b1, "R3 reset ready", 128'(rsv_ready), 128'(1));
    chk(in_ready == '0, "R9 reset in_ready", 128'(in_ready), 128'(0));
    chk(out_valid == '0, "R10 reset out_valid", 128'(out_valid), 128'(0));
    chk(out_data == '0, "R10 reset out_data", 128'(out_data), 128'(0));
  endtask

  task automatic t_basic;
    do_rsv(W, E, 1, 0, "R1 W->E");
    run_flits(5'b01000, '{0, 0, 0, E, 0}, 1, "R2 R10 W->E");
    @(negedge clk); in_valid[W] = 1'b1; #1;
    chk(in_ready[W] == 1'b0, "R7 released after tail", 128'(in_ready[W]), 128'(0));
    chk(out_valid[E] == 1'b0, "R7 no flow after tail", 128'(out_valid[E]), 128'(0));
    in_valid = '0;
  endtask

  task automatic t_hold;
    @(negedge clk); in_valid[N] = 1'b1; in_data[N*FW +: FW] = flit(2, N, 0);
    for (int c = 0; c < 4; c++) begin
      @(negedge clk); #1;
      chk(in_ready[N] == 1'b0, "R9 held in_ready", 128'(in_ready[N]), 128'(0));
      chk(out_valid == '0, "R9 held out_valid", 128'(out_valid), 128'(0));
    end
    do_rsv(N, S, 1, 0, "R1 N->S");
    run_flits(5'b00001, '{S, 0, 0, 0, 0}, 2, "R9 N->S after reserve");
  endtask

  task automatic t_order;
    do_rsv(L, E, 1, 0, "R1 L->E");
    do_rsv(W, E, 1, 0, "R1 W->E second");
    @(negedge clk); in_valid[W] = 1'b1;
    for (int c = 0; c < 4; c++) begin
      @(negedge clk); #1;
      chk(in_ready[W] == 1'b0, "R5 W waits for L", 128'(in_ready[W]), 128'(0));
    end
    run_flits(5'b11000, '{0, 0, 0, E, E}, 3, "R5 ordered into E");
  endtask

  task automatic t_busy;
    do_rsv(W, E, 1, 0, "R1 W->E busy first");
    fork
      run_flits(5'b01000, '{0, 0, 0, E, 0}, 4, "R4 first packet");
      begin
        repeat (4) @(negedge clk);
        do_rsv(W, E, 1, 0, "R4 reserve while busy");
      end
    join
    run_flits(5'b01000, '{0, 0, 0, E, 0}, 5, "R4 second packet");
  endtask

  task automatic t_parallel;
    do_rsv(N, S, 1, 0, "R6 N->S");
    do_rsv(S, N, 1, 0, "R6 S->N");
    do_rsv(E, W, 1, 0, "R6 E->W");
    do_rsv(W, E, 1, 0, "R6 W->E");
    do_rsv(L, L, 1, 0, "R8 L->L legal");
    run_flits(5'b11111, '{S, N, W, E, L}, 6, "R6 five circuits");
  endtask

  task automatic t_full;
    for (int j = 0; j < QD; j++) do_rsv(N, S, 1, 0, "R3 fill N->S");
    do_rsv(N, S, 0, 1, "R3 R8 both full");
    do_rsv(N, E, 0, 1, "R3 input queue full");
    do_rsv(E, S, 0, 1, "R3 output queue full");
    do_rsv(E, W, 1, 0, "R3 other ports free");
    run_flits(5'b00100, '{0, 0, W, 0, 0}, 7, "R3 E->W");
    for (int j = 0; j < QD; j++) run_flits(5'b00001, '{S, 0, 0, 0, 0}, 8 + j, "R3 drain N->S");
    @(negedge clk); in_valid[N] = 1'b1;
    repeat (3) @(negedge clk);
    #1;
    chk(in_ready[N] == 1'b0, "R8 refused not queued", 128'(in_ready[N]), 128'(0));
    in_valid = '0;
  endtask

  task automatic t_illegal;
    do_rsv(E, E, 1, 1, "R8 U-turn");
    do_rsv(5, S, 1, 1, "R8 bad index");
    do_rsv(E, W, 1, 0, "R1 E->W after illegal");
    run_flits(5'b00100, '{0, 0, W, 0, 0}, 20, "R8 U-turn not queued");
    @(negedge clk); in_valid[S] = 1'b1; #1;
    chk(in_ready[S] == 1'b0, "R8 bad index not queued", 128'(in_ready[S]), 128'(0));
    in_valid = '0;
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    t_reset();
    t_basic();
    t_hold();
    t_order();
    t_busy();
    t_parallel();
    t_full();
    t_illegal();
    repeat (2) @(negedge clk);
    finished = 1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!finished) begin
      chk(1'b0, "watchdog", 128'(0), 128'(1));
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
    end
  end
endmodule